// File: doc/BRIEF.md
# Predicated Execution Condition Evaluator

This block decides, one pipeline stage after an instruction is presented, whether that instruction is allowed to run. It reads the 4-bit predicate held in the top bits of the instruction word. It tests that predicate against a locally held set of four status flags: negative, zero, carry and overflow. It then raises either an execute or a skip indication. The predicate code that means "always" bypasses the flags. The one code that has no meaning is reported on a separate reserved output, and that instruction never executes.

The block also keeps the status flags. When a flag-setting operation is presented with its update enable high and its predicate passes, the new flag values are captured at the same clock edge. The next instruction is then judged against them. An instruction whose predicate fails, or whose code is reserved, leaves the flags alone even if it asks to update them.

Top module: `pred_gate`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `exec_o`, `skip_o` and `rsvd_o` are low and `flags_o` is 4'b0000.
- R2: Only instruction bits 31 to 28 (the predicate code) affect the decision; bits 27 to 0 have no effect on any output.
- R3: Outputs are registered: the result for an instruction presented with `in_valid_i` high at a clock edge appears on the outputs just after that edge. An edge with `in_valid_i` low gives `exec_o`, `skip_o` and `rsvd_o` all low.
- R4: With `flags_o` bit order {N,Z,C,V} = bits {3,2,1,0}, the predicate codes pass as follows: 0000 Z; 0001 !Z; 0010 C; 0011 !C; 0100 N; 0101 !N; 0110 V; 0111 !V; 1000 C&!Z; 1001 !C|Z; 1010 N==V; 1011 N!=V; 1100 !Z&(N==V); 1101 Z|(N!=V).
- R5: Code 1110 always executes, whatever the flags hold.
- R6: Code 1111 is reserved. A valid instruction carrying it gives `rsvd_o` high, `exec_o` low and `skip_o` high.
- R7: A valid instruction whose predicate fails gives `skip_o` high and `exec_o` low. `exec_o` and `skip_o` are never high together.
- R8: When `in_valid_i`, `upd_en_i` and a passing predicate coincide at an edge, `flags_o` takes `new_flags_i` at that edge, and the next instruction is judged against the new value.
- R9: The flags keep their value when `upd_en_i` is low, when `in_valid_i` is low, when the predicate fails, or when the code is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid_i | input | 1 | Instruction present this cycle |
| instr_i | input | 32 | Instruction word; predicate in bits 31:28 |
| upd_en_i | input | 1 | Instruction wants to set the status flags |
| new_flags_i | input | 4 | Flag values to load, {N,Z,C,V} |
| exec_o | output | 1 | Registered: instruction executes |
| skip_o | output | 1 | Registered: instruction is squashed |
| rsvd_o | output | 1 | Registered: reserved predicate code seen |
| flags_o | output | 4 | Current status flags, {N,Z,C,V} |

## Verification
The main check sweeps every predicate code against every flag pattern. The flags are set through the block's own update path before each probe, so a wrong term in any single predicate, or a swapped flag bit, shows up on exactly the combinations where it differs from the independent reference. Separate probes keep the predicate fixed and vary the low 28 bits, to show that no other field leaks into the decision. Update probes pair passing, failing and reserved codes with the update enable high. These tell a correct flag-load gate apart from one that ignores the predicate or the valid strobe, and they check that the instruction after an update sees the new flags.

// File: rtl/pred_pkg.sv
package pred_pkg;

  // Status flags, most significant first: negative, zero, carry, overflow
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  localparam int unsigned FLAG_W = $bits(nzcv_t);
  localparam int unsigned COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    P_ZSET  = 4'd0,
    P_ZCLR  = 4'd1,
    P_CSET  = 4'd2,
    P_CCLR  = 4'd3,
    P_NSET  = 4'd4,
    P_NCLR  = 4'd5,
    P_VSET  = 4'd6,
    P_VCLR  = 4'd7,
    P_UGT   = 4'd8,
    P_ULE   = 4'd9,
    P_SGE   = 4'd10,
    P_SLT   = 4'd11,
    P_SGT   = 4'd12,
    P_SLE   = 4'd13,
    P_ALW   = 4'd14,
    P_RSVD  = 4'd15
  } pred_e;

endpackage

// File: rtl/pred_cond_eval.sv
module pred_cond_eval
  import pred_pkg::*;
(
  input  logic [COND_W-1:0] code_i,
  input  nzcv_t             flags_i,
  output logic              pass_o,
  output logic              rsvd_o
);

  logic sign_eq;

  always_comb begin
    sign_eq = (flags_i.n == flags_i.v);
    pass_o  = 1'b0;
    rsvd_o  = 1'b0;
    case (pred_e'(code_i))
      P_ZSET: pass_o = flags_i.z;
      P_ZCLR: pass_o = !flags_i.z;
      P_CSET: pass_o = flags_i.c;
      P_CCLR: pass_o = !flags_i.c;
      P_NSET: pass_o = flags_i.n;
      P_NCLR: pass_o = !flags_i.n;
      P_VSET: pass_o = flags_i.v;
      P_VCLR: pass_o = !flags_i.v;
      P_UGT:  pass_o = flags_i.c && !flags_i.z;
      P_ULE:  pass_o = !flags_i.c || flags_i.z;
      P_SGE:  pass_o = sign_eq;
      P_SLT:  pass_o = !sign_eq;
      P_SGT:  pass_o = !flags_i.z && sign_eq;
      P_SLE:  pass_o = flags_i.z || !sign_eq;
      P_ALW:  pass_o = 1'b1;
      default: begin
        pass_o = 1'b0;
        rsvd_o = 1'b1;
      end
    endcase
  end

  // R6
  always_comb begin
    rsvd_never_pass_chk: assert (!(rsvd_o && pass_o));
  end

endmodule

// File: rtl/pred_flag_reg.sv
module pred_flag_reg
  import pred_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load_i,
  input  nzcv_t d_i,
  output nzcv_t q_o
);

  always_ff @(posedge clk) begin
    if (rst)
      q_o <= '0;
    else if (load_i)
      q_o <= d_i;
  end

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load_i)) |-> $stable(q_o));

endmodule

// File: rtl/pred_gate.sv
module pred_gate
  import pred_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] instr_i,
  input  logic              upd_en_i,
  input  logic [FLAG_W-1:0] new_flags_i,
  output logic              exec_o,
  output logic              skip_o,
  output logic              rsvd_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int unsigned COND_LSB = DATA_W - COND_W;

  logic [COND_W-1:0] code;
  logic              pass;
  logic              rsvd;
  logic              flag_load;
  nzcv_t             cur_flags;
  logic              unused_low_bits;

  assign code            = instr_i[DATA_W-1:COND_LSB];
  assign unused_low_bits = ^instr_i[COND_LSB-1:0];

  pred_cond_eval u_eval (
    .code_i  (code),
    .flags_i (cur_flags),
    .pass_o  (pass),
    .rsvd_o  (rsvd)
  );

  assign flag_load = in_valid_i && upd_en_i && pass;

  pred_flag_reg u_flags (
    .clk    (clk),
    .rst    (rst),
    .load_i (flag_load),
    .d_i    (nzcv_t'(new_flags_i)),
    .q_o    (cur_flags)
  );

  assign flags_o = cur_flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_o <= 1'b0;
      skip_o <= 1'b0;
      rsvd_o <= 1'b0;
    end else begin
      exec_o <= in_valid_i && pass;
      skip_o <= in_valid_i && !pass;
      rsvd_o <= in_valid_i && rsvd;
    end
  end

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid_i) |-> (!exec_o && !skip_o && !rsvd_o));

  // R7
  exec_skip_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(exec_o && skip_o));

  // R6
  rsvd_no_exec_chk: assert property (@(posedge clk) disable iff (rst)
    rsvd_o |-> (skip_o && !exec_o));

  // R5
  always_code_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid_i && (instr_i[DATA_W-1:COND_LSB] == 4'hE)))
      |-> exec_o);

  // R8
  flag_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid_i && upd_en_i) && exec_o)
      |-> (flags_o == $past(new_flags_i)));

endmodule

// File: tb/pred_gate_tb.sv
module pred_gate_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        upd_en_i = 1'b0;
  logic [3:0]  new_flags_i = '0;
  logic        exec_o, skip_o, rsvd_o;
  logic [3:0]  flags_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pred_gate u_dut (
    .clk         (clk),
    .rst         (rst),
    .in_valid_i  (in_valid_i),
    .instr_i     (instr_i),
    .upd_en_i    (upd_en_i),
    .new_flags_i (new_flags_i),
    .exec_o      (exec_o),
    .skip_o      (skip_o),
    .rsvd_o      (rsvd_o),
    .flags_o     (flags_o)
  );

  // Reference predicate, written from the requirement table; f = {N,Z,C,V}
  function automatic logic ref_pass(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Present one cycle of input, then sample 2 ns after the edge
  task automatic step(input logic v, input logic [31:0] ins,
                      input logic ue, input logic [3:0] nf);
    in_valid_i  = v;
    instr_i     = ins;
    upd_en_i    = ue;
    new_flags_i = nf;
    @(posedge clk);
    #2;
  endtask

  task automatic load_flags(input logic [3:0] f);
    step(1'b1, 32'hE000_0000, 1'b1, f);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(1'b1, 32'hE000_0000, 1'b1, 4'hF);
    chk("R1", "exec in reset", exec_o, 0);
    chk("R1", "skip in reset", skip_o, 0);
    chk("R1", "rsvd in reset", rsvd_o, 0);
    chk("R1", "flags in reset", flags_o, 0);
    rst = 1'b0;
    step(1'b0, 32'h0, 1'b0, 4'h0);
    chk("R1", "exec after reset", exec_o, 0);
    chk("R1", "flags after reset", flags_o, 0);
  endtask

  task automatic t_sweep();
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        logic e;
        load_flags(4'(f));
        e = ref_pass(4'(c), 4'(f));
        step(1'b1, {4'(c), 28'h0ABCDEF}, 1'b0, 4'h0);
        chk((c == 14) ? "R5" : (c == 15) ? "R6" : "R4", "exec sweep", exec_o, e);
        chk("R7", "skip sweep", skip_o, !e);
        chk("R6", "rsvd sweep", rsvd_o, c == 15);
      end
    end
  endtask

  task automatic t_low_bits();
    load_flags(4'b0100);
    step(1'b1, 32'h0000_0000, 1'b0, 4'h0);
    chk("R2", "EQ low zeros", exec_o, 1);
    step(1'b1, 32'h0FFF_FFFF, 1'b0, 4'h0);
    chk("R2", "EQ low ones", exec_o, 1);
    load_flags(4'b0000);
    step(1'b1, 32'h0FFF_FFFF, 1'b0, 4'h0);
    chk("R2", "EQ fail low ones", exec_o, 0);
    step(1'b1, 32'h1000_0000, 1'b0, 4'h0);
    chk("R2", "NE low zeros", exec_o, 1);
  endtask

  task automatic t_idle();
    step(1'b0, 32'hE000_0000, 1'b0, 4'h0);
    chk("R3", "idle exec", exec_o, 0);
    chk("R3", "idle skip", skip_o, 0);
    step(1'b0, 32'hF000_0000, 1'b0, 4'h0);
    chk("R3", "idle rsvd", rsvd_o, 0);
  endtask

  task automatic t_flag_update();
    load_flags(4'b0000);
    // failing predicate with update request: flags untouched
    step(1'b1, 32'h0000_0000, 1'b1, 4'b1111);
    chk("R9", "fail keeps flags", flags_o, 4'b0000);
    chk("R7", "fail skip", skip_o, 1);
    // passing predicate with update: load
    step(1'b1, 32'h1000_0000, 1'b1, 4'b0100);
    chk("R8", "pass loads flags", flags_o, 4'b0100);
    // next instruction sees Z set
    step(1'b1, 32'h0000_0000, 1'b0, 4'h0);
    chk("R8", "next uses new flags", exec_o, 1);
    // reserved with update
    step(1'b1, 32'hF000_0000, 1'b1, 4'b1011);
    chk("R9", "reserved keeps flags", flags_o, 4'b0100);
    // invalid with update
    step(1'b0, 32'hE000_0000, 1'b1, 4'b1011);
    chk("R9", "invalid keeps flags", flags_o, 4'b0100);
    // enable low on passing code
    step(1'b1, 32'hE000_0000, 1'b0, 4'b1011);
    chk("R9", "enable low keeps flags", flags_o, 4'b0100);
    // back-to-back updates
    step(1'b1, 32'hE000_0000, 1'b1, 4'b1001);
    step(1'b1, 32'hA000_0000, 1'b1, 4'b0010);
    chk("R8", "GE with N==V loads", flags_o, 4'b0010);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle();
    t_sweep();
    t_low_bits();
    t_flag_update();
    t_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule